// File: doc/BRIEF.md
# Doorbell and Link-Event Interrupt Unit

This block sits on one side of a non-transparent bridge and gathers the events that the local host must service. Sixteen doorbell bits are raised by the far side through a set-only write port. The local host clears them, masks them and unmasks them through a 32-bit register port. A 4-bit link-event word records correctable errors, uncorrectable errors, loss of the data link and dropped uncorrectable messages. It is raised by hardware event inputs, cleared by the host, and has its own mask.

Two interrupt forms come out of the block. A level output stays high while any unmasked event is pending. A one-cycle message pulse marks every moment at which software must look again. That moment is a newly visible pending bit, or a clear that left visible bits behind, and not only the step of the whole word away from zero.

The message pulse comes from a three-state machine: `M_QUIET` (nothing visible pending), `M_FIRE` (pulse cycle) and `M_HOLD` (visible bits pending, already signalled). The transitions are: QUIET→FIRE on a trigger; FIRE→FIRE and HOLD→FIRE on a further trigger; FIRE→HOLD and HOLD→HOLD with no trigger while visible bits remain; FIRE→QUIET and HOLD→QUIET with no trigger once nothing visible is pending.

Host register index (`host_addr`): 0 doorbell status (read-only), 1 doorbell clear (write-one-to-clear, reads status), 2 mask set (reads mask), 3 mask clear (reads mask), 4 link status (write-one-to-clear), 5 link mask (written as a whole value). Indices 6 and 7 read zero.

Top module: `bridge_bell_irq`

## Requirements
- R1: The doorbell word is 16 bits wide. Register bits 31..16 always read zero, and data bits above 15 on either write port have no effect. A write to index 0 changes nothing.
- R2: A peer write sets every doorbell bit whose data bit is one and leaves the bits written with zero unchanged.
- R3: A host write to index 1 clears every doorbell bit whose data bit is one and leaves the others unchanged.
- R4: Writing ones to index 2 sets mask bits, and writing ones to index 3 clears mask bits. Masking never changes the doorbell status.
- R5: If a peer set and a host clear hit the same doorbell bit in one cycle, the bit ends up set.
- R6: `irq_level` is high in the cycle after a register update exactly when some doorbell bit is set and unmasked, or some link bit is set and unmasked.
- R7: Link status bit 0 is correctable error, bit 1 uncorrectable error, bit 2 data-link down and bit 3 dropped uncorrectable message. Each bit is set by the matching `link_event` input and cleared by writing one to index 4. A set wins over a clear in the same cycle.
- R8: The link mask resets to 0xF. A write to index 5 loads the mask from data bits 3..0, so 0xF masks all four bits and 0 unmasks them all.
- R9: A message pulse follows whenever a bit becomes visible (set and unmasked) that was not visible before. This includes a new bit while others are pending, and the unmasking of a bit that is still pending.
- R10: A message pulse follows a clear that removes visible bits while other visible bits remain. No pulse follows a clear that leaves nothing visible, or the masking of a pending bit.
- R11: `irq_msg` is high for one cycle per triggering update. It appears in the second cycle after the write edge that caused it, and it is never high unless something was visible in the cycle before.
- R12: After reset all doorbell status, doorbell mask and link status bits are zero, the link mask is 0xF, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| peer_set | input | 1 | Peer doorbell set strobe |
| peer_data | input | 32 | Peer doorbell bits to set |
| link_event | input | 4 | Hardware link-event pulses |
| irq_level | output | 1 | Level interrupt |
| irq_msg | output | 1 | One-cycle message interrupt pulse |

## Verification
The hardest case to reach is the pair of message triggers that a zero-crossing detector would miss. The first is a partial clear while unmasked bits remain. The second is the unmasking of a bit that has stayed pending behind its mask. To reach both, the stimulus first builds up several pending doorbells, some masked. It then clears part of them, masks another bit, and finally unmasks the hidden bit, checking the pulse cycle by cycle against a model of the status and mask words. Further sweeps set every doorbell bit in turn on top of the ones already pending, and step the link mask through all sixteen values.

// File: rtl/bell_pkg.sv
`timescale 1ns/1ps
package bell_pkg;
    localparam int DB_BITS   = 16;
    localparam int LINK_BITS = 4;

    // host register index; values are decoded by the top module
    typedef enum logic [2:0] {
        A_DB_STAT  = 3'd0,
        A_DB_CLR   = 3'd1,
        A_MSK_SET  = 3'd2,
        A_MSK_CLR  = 3'd3,
        A_LNK_STAT = 3'd4,
        A_LNK_MSK  = 3'd5
    } reg_idx_e;

    typedef enum logic [1:0] {
        M_QUIET = 2'd0,
        M_FIRE  = 2'd1,
        M_HOLD  = 2'd2
    } msg_state_e;
endpackage

// File: rtl/bell_reg_bank.sv
`timescale 1ns/1ps
module bell_reg_bank #(
    parameter int          W        = 16,
    parameter logic [W-1:0] MASK_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] msk_set,
    input  logic [W-1:0] msk_clr,
    input  logic         msk_load_en,
    input  logic [W-1:0] msk_load,
    output logic [W-1:0] status,
    output logic [W-1:0] mask
);
    logic [W-1:0] status_nxt;
    logic [W-1:0] mask_nxt;

    always_comb begin
        // set applied after clear: a coinciding set survives
        status_nxt = (status & ~clr_bits) | set_bits;
        if (msk_load_en)
            mask_nxt = msk_load;
        else
            mask_nxt = (mask | msk_set) & ~msk_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= MASK_RST;
        end else begin
            status <= status_nxt;
            mask   <= mask_nxt;
        end
    end

    // R5 / R7: bits named by a set are present after the edge
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((status & $past(set_bits)) == $past(set_bits)));

    // R4: mask traffic alone leaves status alone
    p_mask_keeps_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_bits == '0) && (clr_bits == '0)) |=> $stable(status));
endmodule

// File: rtl/bell_msg_fsm.sv
`timescale 1ns/1ps
module bell_msg_fsm
    import bell_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] eff,
    output logic         irq_msg
);
    msg_state_e   state, state_nxt;
    logic [W-1:0] eff_prev;
    logic         new_vis;
    logic         part_clr;
    logic         trig;

    always_comb begin
        new_vis  = |(eff & ~eff_prev);
        // a previously visible bit whose status dropped (not merely masked)
        part_clr = (|(eff_prev & ~status)) && (|eff);
        trig     = new_vis || part_clr;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            M_QUIET: state_nxt = trig ? M_FIRE : M_QUIET;
            M_FIRE,
            M_HOLD:  state_nxt = trig ? M_FIRE : ((|eff) ? M_HOLD : M_QUIET);
            default: state_nxt = M_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= M_QUIET;
            eff_prev <= '0;
        end else begin
            state    <= state_nxt;
            eff_prev <= eff;
        end
    end

    always_comb irq_msg = (state == M_FIRE);

    // R9: a newly visible bit yields a pulse on the next cycle
    p_new_bit_fires_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(eff & ~eff_prev)) |=> irq_msg);

    // R10: nothing visible means no pulse follows
    p_empty_no_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == '0) |=> !irq_msg);

    // R11: a pulse always has a visible cause one cycle earlier
    p_pulse_needs_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg |-> $past(|eff));
endmodule

// File: rtl/bridge_bell_irq.sv
`timescale 1ns/1ps
module bridge_bell_irq
    import bell_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DB_W   = DB_BITS,
    parameter int LNK_W  = LINK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              peer_set,
    input  logic [DATA_W-1:0] peer_data,
    input  logic [LNK_W-1:0]  link_event,
    output logic              irq_level,
    output logic              irq_msg
);
    localparam int ALL_W = DB_W + LNK_W;

    logic [DB_W-1:0]  db_set, db_clr, db_mset, db_mclr, db_st, db_mk;
    logic [LNK_W-1:0] ln_clr, ln_st, ln_mk;
    logic             ln_load;
    logic [ALL_W-1:0] all_st, all_eff;
    logic             unused_hi;

    assign unused_hi = ^{host_wdata[DATA_W-1:DB_W], peer_data[DATA_W-1:DB_W]};

    always_comb begin
        db_set  = peer_set ? peer_data[DB_W-1:0] : '0;
        db_clr  = (host_wr && host_addr == A_DB_CLR)   ? host_wdata[DB_W-1:0]  : '0;
        db_mset = (host_wr && host_addr == A_MSK_SET)  ? host_wdata[DB_W-1:0]  : '0;
        db_mclr = (host_wr && host_addr == A_MSK_CLR)  ? host_wdata[DB_W-1:0]  : '0;
        ln_clr  = (host_wr && host_addr == A_LNK_STAT) ? host_wdata[LNK_W-1:0] : '0;
        ln_load = host_wr && (host_addr == A_LNK_MSK);
    end

    bell_reg_bank #(.W(DB_W), .MASK_RST('0)) u_db (
        .clk(clk), .rst_n(rst_n),
        .set_bits(db_set), .clr_bits(db_clr),
        .msk_set(db_mset), .msk_clr(db_mclr),
        .msk_load_en(1'b0), .msk_load('0),
        .status(db_st), .mask(db_mk)
    );

    bell_reg_bank #(.W(LNK_W), .MASK_RST('1)) u_link (
        .clk(clk), .rst_n(rst_n),
        .set_bits(link_event), .clr_bits(ln_clr),
        .msk_set('0), .msk_clr('0),
        .msk_load_en(ln_load), .msk_load(host_wdata[LNK_W-1:0]),
        .status(ln_st), .mask(ln_mk)
    );

    always_comb begin
        all_st    = {ln_st, db_st};
        all_eff   = {ln_st & ~ln_mk, db_st & ~db_mk};
        irq_level = |all_eff;
    end

    bell_msg_fsm #(.W(ALL_W)) u_msg (
        .clk(clk), .rst_n(rst_n),
        .status(all_st), .eff(all_eff),
        .irq_msg(irq_msg)
    );

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_DB_STAT, A_DB_CLR:  host_rdata[DB_W-1:0]  = db_st;
            A_MSK_SET, A_MSK_CLR: host_rdata[DB_W-1:0]  = db_mk;
            A_LNK_STAT:           host_rdata[LNK_W-1:0] = ln_st;
            A_LNK_MSK:            host_rdata[LNK_W-1:0] = ln_mk;
            default:              host_rdata = '0;
        endcase
    end

    // R1: nothing ever appears above the doorbell width
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[DATA_W-1:DB_W] == '0);

    // R6: the level output tracks a pending, unmasked link event
    p_link_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ln_st & ~ln_mk)) |-> irq_level);
endmodule

// File: tb/test_bridge_bell_irq.sv
`timescale 1ns/1ps
module test_bridge_bell_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        peer_set = 1'b0;
    logic [31:0] peer_data = '0;
    logic [3:0]  link_event = '0;
    logic        irq_level, irq_msg;

    always #4 clk = ~clk;

    bridge_bell_irq i_bridge_bell_irq (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .peer_set(peer_set), .peer_data(peer_data),
        .link_event(link_event),
        .irq_level(irq_level), .irq_msg(irq_msg)
    );

    int checks = 0;
    int fails  = 0;

    // model of the requirement-level state
    logic [15:0] m_db = '0, m_mk = '0;
    logic [3:0]  m_ls = '0, m_lm = 4'hF;
    logic        pend_trig = 1'b0;
    logic        exp_msg = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return {16'h0, m_db};
            3'd2, 3'd3: return {16'h0, m_mk};
            3'd4:       return {28'h0, m_ls};
            3'd5:       return {28'h0, m_lm};
            default:    return 32'h0;
        endcase
    endfunction

    // called at a negedge, returns at the next negedge
    task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                       input logic ps, input logic [31:0] pd, input logic [3:0] lev);
        logic [19:0] eo, en, sn;
        logic [15:0] ndb, nmk;
        logic [3:0]  nls, nlm;
        logic        lvl;
        host_wr = wr; host_addr = a; host_wdata = wd;
        peer_set = ps; peer_data = pd; link_event = lev;
        ndb = m_db;
        if (wr && a == 3'd1) ndb = ndb & ~wd[15:0];
        if (ps) ndb = ndb | pd[15:0];
        nmk = m_mk;
        if (wr && a == 3'd2) nmk = nmk | wd[15:0];
        if (wr && a == 3'd3) nmk = nmk & ~wd[15:0];
        nls = m_ls;
        if (wr && a == 3'd4) nls = nls & ~wd[3:0];
        nls = nls | lev;
        nlm = (wr && a == 3'd5) ? wd[3:0] : m_lm;
        @(posedge clk);
        exp_msg = pend_trig;
        eo = {m_ls & ~m_lm, m_db & ~m_mk};
        en = {nls & ~nlm, ndb & ~nmk};
        sn = {nls, ndb};
        pend_trig = (|(en & ~eo)) || ((|(eo & ~sn)) && (|en));
        m_db = ndb; m_mk = nmk; m_ls = nls; m_lm = nlm;
        @(negedge clk);
        host_wr = 1'b0; peer_set = 1'b0; link_event = '0;
        lvl = |en;
        chk(irq_level == lvl, "R6 level", {31'h0, irq_level}, {31'h0, lvl});
        chk(irq_msg == exp_msg, "R9 R10 R11 message pulse", {31'h0, irq_msg}, {31'h0, exp_msg});
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 3'd0, '0, 1'b0, '0, '0);
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        logic [31:0] e;
        host_addr = a;
        #1;
        e = mread(a);
        chk(host_rdata == e, req, host_rdata, e);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset values
        for (int a = 0; a < 8; a++) rd(a[2:0], "R12 reset register");
        chk(irq_level == 1'b0, "R12 reset level", {31'h0, irq_level}, 32'h0);
        chk(irq_msg == 1'b0, "R12 reset pulse", {31'h0, irq_msg}, 32'h0);
        idle(2);

        // R1: index 0 is read-only, high bits inert
        cyc(1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, '0, '0);
        rd(3'd0, "R1 write to status ignored");
        cyc(1'b0, 3'd0, '0, 1'b1, 32'hFFFF_0000, '0);
        rd(3'd0, "R1 upper peer bits ignored");
        cyc(1'b0, 3'd0, '0, 1'b1, 32'hFFFF_FFFF, '0);
        rd(3'd0, "R1 only 16 bits");
        idle(2);
        cyc(1'b1, 3'd1, 32'hFFFF_FFFF, 1'b0, '0, '0);
        rd(3'd1, "R3 clear all");
        idle(2);

        // R2: walk one new bit per step on top of pending ones
        for (int i = 0; i < 16; i++) begin
            cyc(1'b0, 3'd0, '0, 1'b1, 32'h1 << i, '0);
            rd(3'd0, "R2 peer set accumulates");
            idle(1);
        end
        // R10: partial clear leaves bits pending
        cyc(1'b1, 3'd1, 32'h0000_5555, 1'b0, '0, '0);
        rd(3'd0, "R3 partial clear");
        idle(2);
        cyc(1'b1, 3'd1, 32'h0000_AAAA, 1'b0, '0, '0);
        rd(3'd0, "R3 final clear, R10 no pulse");
        idle(2);

        // R4: masking hides without clearing; unmasking a pending bit fires
        cyc(1'b1, 3'd2, 32'h0000_00FF, 1'b0, '0, '0);
        rd(3'd2, "R4 mask set");
        cyc(1'b0, 3'd0, '0, 1'b1, 32'h0000_0101, '0);
        idle(2);
        cyc(1'b1, 3'd1, 32'h0000_0100, 1'b0, '0, '0);
        rd(3'd0, "R4 masked bit kept");
        idle(2);
        cyc(1'b0, 3'd0, '0, 1'b1, 32'h0000_0600, '0);
        idle(1);
        cyc(1'b1, 3'd2, 32'h0000_0200, 1'b0, '0, '0);
        rd(3'd0, "R4 masking keeps status R10 no pulse");
        idle(2);
        cyc(1'b1, 3'd3, 32'h0000_0201, 1'b0, '0, '0);
        rd(3'd3, "R4 mask clear R9 unmask fires");
        idle(2);

        // R5: simultaneous set and clear of the same bit
        cyc(1'b1, 3'd1, 32'h0000_FFFF, 1'b1, 32'h0000_8001, '0);
        rd(3'd0, "R5 set wins");
        idle(2);
        cyc(1'b1, 3'd1, 32'h0000_FFFF, 1'b0, '0, '0);
        cyc(1'b1, 3'd3, 32'h0000_FFFF, 1'b0, '0, '0);
        idle(2);

        // R7 / R8: sweep the link mask over all values
        for (int v = 0; v < 16; v++) begin
            cyc(1'b1, 3'd5, v, 1'b0, '0, '0);
            rd(3'd5, "R8 link mask load");
            cyc(1'b0, 3'd0, '0, 1'b0, '0, 4'hF);
            rd(3'd4, "R7 link events latched");
            idle(1);
            cyc(1'b1, 3'd4, 32'h0000_0005, 1'b0, '0, '0);
            rd(3'd4, "R7 link partial clear");
            cyc(1'b1, 3'd4, 32'h0000_000F, 1'b0, '0, 4'h2);
            rd(3'd4, "R7 set beats clear");
            cyc(1'b1, 3'd4, 32'h0000_000F, 1'b0, '0, '0);
            idle(1);
        end
        // mixed doorbell and link pending
        cyc(1'b0, 3'd0, '0, 1'b1, 32'h0000_0010, 4'h4);
        idle(1);
        cyc(1'b1, 3'd1, 32'h0000_0010, 1'b0, '0, '0);
        idle(2);
        cyc(1'b1, 3'd4, 32'h0000_0004, 1'b0, '0, '0);
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule